// File: doc/BRIEF.md
# Two-Sided Translation Buffer with Access Protection

This block keeps a pair of translation buffers, one serving instruction fetches and one serving data loads and stores. Each buffer is 4-way set-associative with 16 sets. An entry is a 64-bit pair. The tag word carries a virtual page number and an 8-bit process tag. The page word carries a physical page number and five attribute flags. Software fills entries through a write port that names the buffer, the way and the set.

A lookup presents a virtual address, an access kind, a user-mode flag, the current process tag and a protection configuration word. One cycle later the block returns the physical page, a permission set, a fault flag and an exception vector number. A hitting entry can still be turned into a fault by a fixed-priority chain of protection checks, and each check is enabled by its own configuration bit. The instruction side and the data side report failures on separate vector numbers.

A flush scan walks every entry of both buffers at one entry per cycle. It reports each valid, non-global entry that carries a given process tag, so that the caller can drop those pages from any downstream cache of translations.

Top module: `tlb_guard`

## Requirements
- R1: The set index is virtual address bits 16:13 and the page number is bits 31:13. Tag word bits 31:13 hold the page number and bits 7:0 hold the process tag. Page word bits 31:13 hold the physical page, bit 4 global, bit 3 valid, bit 2 kernel, bit 1 writable and bit 0 executable. A way hits when its page number matches and either its global bit is set or its tag equals lk_pid_i.
- R2: When several ways hit, the lowest-numbered way supplies the result.
- R3: lk_kind_i encodes 0 read, 1 write, 2 execute, and 3 is treated as a read. Execute uses buffer 0 (instruction). All other kinds use buffer 1 (data).
- R4: A hit is checked in this fixed order, and the first check that applies makes it a fault: user access to a kernel page when cfg bit 18 is set, write to a non-writable page when cfg bit 19 is set, execute of a non-executable page when cfg bit 17 is set, then a non-valid entry when cfg bit 16 is set. The other cfg bits have no effect.
- R5: rs_vec_o is the side base (4 for instruction, 8 for data) plus an offset: 0 for a miss or a success, 1 for invalid, 2 for kernel, 3 for write or execute.
- R6: On success rs_perm_o bit 0 (read) is 1 and bit 1 (write) equals the writable flag. Bit 2 (execute) is 1 only for an execute access with cfg bit 17 or the executable flag set. On any fault rs_perm_o is 0. rs_ppn_o is the hitting entry's physical page, or 0 on a miss.
- R7: rs_valid_o is high in exactly the cycle after a cycle with lk_valid_i high, and the result belongs to that request.
- R8: A write through the fill port replaces the addressed entry and is seen by any lookup issued in a later cycle.
- R9: fl_start_i, while no scan runs, starts a scan of 128 entries in order buffer, way, set. The scan raises fl_hit_o with the entry address and page number for each entry that is valid, non-global and tagged with fl_pid_i. fl_done_o pulses together with the last entry's result. A start while a scan runs is ignored.
- R10: After reset every entry is zero and rs_valid_o, fl_busy_o, fl_hit_o and fl_done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_tlb_i | input | 1 | Buffer select: 0 instruction, 1 data |
| wr_way_i | input | 2 | Way to write |
| wr_idx_i | input | 4 | Set to write |
| wr_hi_i | input | 32 | Tag word |
| wr_lo_i | input | 32 | Page word |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address |
| lk_kind_i | input | 2 | Access kind |
| lk_user_i | input | 1 | User-mode access |
| lk_pid_i | input | 8 | Current process tag |
| lk_cfg_i | input | 32 | Protection check enables |
| rs_valid_o | output | 1 | Result valid |
| rs_fault_o | output | 1 | Miss or protection fault |
| rs_ppn_o | output | 19 | Physical page number |
| rs_perm_o | output | 3 | Execute, write, read permission |
| rs_vec_o | output | 4 | Exception vector number |
| fl_start_i | input | 1 | Start a flush scan |
| fl_pid_i | input | 8 | Process tag to scan for |
| fl_hit_o | output | 1 | Matching entry strobe |
| fl_tlb_o | output | 1 | Buffer of reported entry |
| fl_way_o | output | 2 | Way of reported entry |
| fl_idx_o | output | 4 | Set of reported entry |
| fl_vpn_o | output | 19 | Page number of reported entry |
| fl_busy_o | output | 1 | Scan running |
| fl_done_o | output | 1 | Scan finished pulse |

## Verification
A corrupted entry, a wrong buffer select or a misordered check chain appears at the ports in the very next cycle after a lookup that touches it. It shows up as a wrong page number, a wrong vector or a permission set that disagrees with the entry flags. Because the lookup set-up draws tags and pages from small pools, several ways often hit at once, so a broken way priority is exposed quickly. A wrong scan counter shows up as missing, duplicated or out-of-order flush reports, or as a done pulse that arrives on any cycle but the 128th after the start.

// File: rtl/tlbg_pkg.sv
package tlbg_pkg;
  localparam int PAGE_SHIFT = 13;
  localparam int VPN_W      = 32 - PAGE_SHIFT;

  localparam int LO_GLB = 4;
  localparam int LO_VLD = 3;
  localparam int LO_KRN = 2;
  localparam int LO_WR  = 1;
  localparam int LO_EX  = 0;

  localparam int CFG_WR  = 19;
  localparam int CFG_KRN = 18;
  localparam int CFG_EX  = 17;
  localparam int CFG_VLD = 16;

  localparam logic [3:0] VEC_ISIDE = 4'd4;
  localparam logic [3:0] VEC_DSIDE = 4'd8;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic             fault;
    logic [3:0]       vec;
    logic [2:0]       perm;
    logic [VPN_W-1:0] ppn;
  } rsp_t;
endpackage

// File: rtl/tlbg_store.sv
module tlbg_store #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      wr_tlb_i,
  input  logic [WAY_W-1:0]          wr_way_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [31:0]               wr_hi_i,
  input  logic [31:0]               wr_lo_i,
  input  logic                      lk_tlb_i,
  input  logic [IDX_W-1:0]          lk_idx_i,
  output logic [NUM_WAYS-1:0][31:0] lk_hi_o,
  output logic [NUM_WAYS-1:0][31:0] lk_lo_o,
  input  logic                      sc_tlb_i,
  input  logic [WAY_W-1:0]          sc_way_i,
  input  logic [IDX_W-1:0]          sc_idx_i,
  output logic [31:0]               sc_hi_o,
  output logic [31:0]               sc_lo_o
);
  logic [31:0] hi_q [2][NUM_WAYS][NUM_SETS];
  logic [31:0] lo_q [2][NUM_WAYS][NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < 2; t++)
        for (int w = 0; w < NUM_WAYS; w++)
          for (int s = 0; s < NUM_SETS; s++) begin
            hi_q[t][w][s] <= '0;
            lo_q[t][w][s] <= '0;
          end
    end else if (wr_en_i) begin
      hi_q[wr_tlb_i][wr_way_i][wr_idx_i] <= wr_hi_i;
      lo_q[wr_tlb_i][wr_way_i][wr_idx_i] <= wr_lo_i;
    end
  end

  for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : g_rd
    assign lk_hi_o[gw] = hi_q[lk_tlb_i][gw][lk_idx_i];
    assign lk_lo_o[gw] = lo_q[lk_tlb_i][gw][lk_idx_i];
  end

  assign sc_hi_o = hi_q[sc_tlb_i][sc_way_i][sc_idx_i];
  assign sc_lo_o = lo_q[sc_tlb_i][sc_way_i][sc_idx_i];
endmodule

// File: rtl/tlbg_match.sv
module tlbg_match
  import tlbg_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int PID_W    = 8
) (
  input  logic [NUM_WAYS-1:0][31:0] hi_i,
  input  logic [NUM_WAYS-1:0][31:0] lo_i,
  input  logic [VPN_W-1:0]          vpn_i,
  input  logic [PID_W-1:0]          pid_i,
  output logic                      hit_o,
  output logic [31:0]               lo_o
);
  logic [NUM_WAYS-1:0] way_hit;

  for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : g_cmp
    assign way_hit[gw] = (hi_i[gw][31:PAGE_SHIFT] == vpn_i) &&
                         (lo_i[gw][LO_GLB] || (hi_i[gw][PID_W-1:0] == pid_i));
  end

  // scan downward so the lowest hitting way is the last to assign
  always_comb begin
    hit_o = 1'b0;
    lo_o  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit_o = 1'b1;
        lo_o  = lo_i[w];
      end
    end
  end
endmodule

// File: rtl/tlbg_check.sv
module tlbg_check
  import tlbg_pkg::*;
(
  input  logic        hit_i,
  input  logic [31:0] lo_i,
  input  acc_e        kind_i,
  input  logic        user_i,
  input  logic [31:0] cfg_i,
  output rsp_t        rsp_o
);
  logic       iside;
  logic [3:0] base;

  assign iside = (kind_i == ACC_EXEC);
  assign base  = iside ? VEC_ISIDE : VEC_DSIDE;

  always_comb begin
    rsp_o       = '0;
    rsp_o.fault = 1'b1;
    rsp_o.vec   = base;
    if (hit_i) begin
      rsp_o.ppn = lo_i[31:PAGE_SHIFT];
      if (cfg_i[CFG_KRN] && lo_i[LO_KRN] && user_i)
        rsp_o.vec = base + 4'd2;
      else if (kind_i == ACC_WRITE && cfg_i[CFG_WR] && !lo_i[LO_WR])
        rsp_o.vec = base + 4'd3;
      else if (iside && cfg_i[CFG_EX] && !lo_i[LO_EX])
        rsp_o.vec = base + 4'd3;
      else if (cfg_i[CFG_VLD] && !lo_i[LO_VLD])
        rsp_o.vec = base + 4'd1;
      else begin
        rsp_o.fault = 1'b0;
        rsp_o.perm  = {iside && (cfg_i[CFG_EX] || lo_i[LO_EX]), lo_i[LO_WR], 1'b1};
      end
    end
  end
endmodule

// File: rtl/tlbg_flush.sv
module tlbg_flush
  import tlbg_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int PID_W    = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int CNT_W = 1 + WAY_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PID_W-1:0]  pid_i,
  output logic              sc_tlb_o,
  output logic [WAY_W-1:0]  sc_way_o,
  output logic [IDX_W-1:0]  sc_idx_o,
  input  logic [31:0]       sc_hi_i,
  input  logic [31:0]       sc_lo_i,
  output logic              hit_o,
  output logic              tlb_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [PID_W-1:0] pid_q;
  logic             busy_q, done_q, hit_q;
  logic             ent_match;

  assign sc_tlb_o  = cnt_q[CNT_W-1];
  assign sc_way_o  = cnt_q[IDX_W +: WAY_W];
  assign sc_idx_o  = cnt_q[IDX_W-1:0];
  assign ent_match = sc_lo_i[LO_VLD] && !sc_lo_i[LO_GLB] &&
                     (sc_hi_i[PID_W-1:0] == pid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pid_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      tlb_o  <= 1'b0;
      way_o  <= '0;
      idx_o  <= '0;
      vpn_o  <= '0;
    end else begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      if (busy_q) begin
        hit_q <= ent_match;
        tlb_o <= sc_tlb_o;
        way_o <= sc_way_o;
        idx_o <= sc_idx_o;
        vpn_o <= sc_hi_i[31:PAGE_SHIFT];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        pid_q  <= pid_i;
      end
    end
  end

  assign hit_o  = hit_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/tlb_guard.sv
module tlb_guard
  import tlbg_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int PID_W    = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_tlb_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_hi_i,
  input  logic [31:0]       wr_lo_i,
  input  logic              lk_valid_i,
  input  logic [31:0]       lk_vaddr_i,
  input  logic [1:0]        lk_kind_i,
  input  logic              lk_user_i,
  input  logic [PID_W-1:0]  lk_pid_i,
  input  logic [31:0]       lk_cfg_i,
  output logic              rs_valid_o,
  output logic              rs_fault_o,
  output logic [VPN_W-1:0]  rs_ppn_o,
  output logic [2:0]        rs_perm_o,
  output logic [3:0]        rs_vec_o,
  input  logic              fl_start_i,
  input  logic [PID_W-1:0]  fl_pid_i,
  output logic              fl_hit_o,
  output logic              fl_tlb_o,
  output logic [WAY_W-1:0]  fl_way_o,
  output logic [IDX_W-1:0]  fl_idx_o,
  output logic [VPN_W-1:0]  fl_vpn_o,
  output logic              fl_busy_o,
  output logic              fl_done_o
);
  acc_e                      kind;
  logic                      lk_tlb;
  logic [NUM_WAYS-1:0][31:0] way_hi, way_lo;
  logic                      hit;
  logic [31:0]               hit_lo;
  logic                      sc_tlb;
  logic [WAY_W-1:0]          sc_way;
  logic [IDX_W-1:0]          sc_idx;
  logic [31:0]               sc_hi, sc_lo;
  rsp_t                      rsp_d, rsp_q;
  logic                      valid_q;

  assign kind   = acc_e'(lk_kind_i);
  assign lk_tlb = (kind != ACC_EXEC);

  tlbg_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_tlb_i, .wr_way_i, .wr_idx_i, .wr_hi_i, .wr_lo_i,
    .lk_tlb_i (lk_tlb),
    .lk_idx_i (lk_vaddr_i[PAGE_SHIFT +: IDX_W]),
    .lk_hi_o  (way_hi),
    .lk_lo_o  (way_lo),
    .sc_tlb_i (sc_tlb),
    .sc_way_i (sc_way),
    .sc_idx_i (sc_idx),
    .sc_hi_o  (sc_hi),
    .sc_lo_o  (sc_lo)
  );

  tlbg_match #(.NUM_WAYS(NUM_WAYS), .PID_W(PID_W)) u_match (
    .hi_i  (way_hi),
    .lo_i  (way_lo),
    .vpn_i (lk_vaddr_i[31:PAGE_SHIFT]),
    .pid_i (lk_pid_i),
    .hit_o (hit),
    .lo_o  (hit_lo)
  );

  tlbg_check u_check (
    .hit_i  (hit),
    .lo_i   (hit_lo),
    .kind_i (kind),
    .user_i (lk_user_i),
    .cfg_i  (lk_cfg_i),
    .rsp_o  (rsp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      valid_q <= lk_valid_i;
      if (lk_valid_i) rsp_q <= rsp_d;
    end
  end

  assign rs_valid_o = valid_q;
  assign rs_fault_o = rsp_q.fault;
  assign rs_ppn_o   = rsp_q.ppn;
  assign rs_perm_o  = rsp_q.perm;
  assign rs_vec_o   = rsp_q.vec;

  tlbg_flush #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .PID_W(PID_W)) u_flush (
    .clk_i, .rst_ni,
    .start_i  (fl_start_i),
    .pid_i    (fl_pid_i),
    .sc_tlb_o (sc_tlb),
    .sc_way_o (sc_way),
    .sc_idx_o (sc_idx),
    .sc_hi_i  (sc_hi),
    .sc_lo_i  (sc_lo),
    .hit_o    (fl_hit_o),
    .tlb_o    (fl_tlb_o),
    .way_o    (fl_way_o),
    .idx_o    (fl_idx_o),
    .vpn_o    (fl_vpn_o),
    .busy_o   (fl_busy_o),
    .done_o   (fl_done_o)
  );
endmodule

// File: rtl/tlbg_chk.sv
module tlbg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lk_valid_i,
  input logic       rs_valid_o,
  input logic       rs_fault_o,
  input logic [2:0] rs_perm_o,
  input logic [3:0] rs_vec_o,
  input logic       fl_hit_o,
  input logic       fl_busy_o,
  input logic       fl_done_o
);
  assert_rsp_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rs_valid_o);
  assert_rsp_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rs_valid_o);
  assert_fault_no_perm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_valid_o && rs_fault_o) |-> (rs_perm_o == 3'b000));
  assert_ok_reads_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_valid_o && !rs_fault_o) |-> rs_perm_o[0]);
  assert_vec_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_o |-> (rs_vec_o >= 4'd4 && rs_vec_o <= 4'd11));
  assert_ok_vec_base_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_valid_o && !rs_fault_o) |-> (rs_vec_o == 4'd4 || rs_vec_o == 4'd8));
  assert_exec_iside_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_valid_o && !rs_fault_o && rs_perm_o[2]) |-> (rs_vec_o == 4'd4));
  assert_flush_hit_in_scan_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_hit_o |-> (fl_busy_o || fl_done_o));
  assert_done_ends_scan_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_done_o |-> (!fl_busy_o && $past(fl_busy_o)));
endmodule

bind tlb_guard tlbg_chk u_chk (
  .clk_i, .rst_ni, .lk_valid_i, .rs_valid_o, .rs_fault_o, .rs_perm_o,
  .rs_vec_o, .fl_hit_o, .fl_busy_o, .fl_done_o
);

// File: tb/sim_tlb_guard.sv
`timescale 1ns/1ps
module sim_tlb_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 0, wr_tlb_i = 0;
  logic [1:0]  wr_way_i = 0;
  logic [3:0]  wr_idx_i = 0;
  logic [31:0] wr_hi_i = 0, wr_lo_i = 0;
  logic        lk_valid_i = 0;
  logic [31:0] lk_vaddr_i = 0;
  logic [1:0]  lk_kind_i = 0;
  logic        lk_user_i = 0;
  logic [7:0]  lk_pid_i = 0;
  logic [31:0] lk_cfg_i = 0;
  logic        rs_valid_o, rs_fault_o;
  logic [18:0] rs_ppn_o;
  logic [2:0]  rs_perm_o;
  logic [3:0]  rs_vec_o;
  logic        fl_start_i = 0;
  logic [7:0]  fl_pid_i = 0;
  logic        fl_hit_o, fl_tlb_o, fl_busy_o, fl_done_o;
  logic [1:0]  fl_way_o;
  logic [3:0]  fl_idx_o;
  logic [18:0] fl_vpn_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];

  always #2 clk_i = ~clk_i;

  tlb_guard u0 (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // {fault, vec[3:0], perm[2:0], ppn[18:0]}
  function automatic logic [26:0] ref_lookup(input logic [31:0] va, input logic [1:0] kd,
                                             input logic usr, input logic [7:0] pid,
                                             input logic [31:0] cfg);
    int t = (kd == 2'd2) ? 0 : 1;
    logic [3:0] base = (kd == 2'd2) ? 4'd4 : 4'd8;
    logic [3:0] idx = va[16:13];
    for (int w = 0; w < 4; w++) begin
      logic [31:0] h = m_hi[t][w][idx];
      logic [31:0] l = m_lo[t][w][idx];
      if (h[31:13] == va[31:13] && (l[4] || h[7:0] == pid)) begin
        if (cfg[18] && l[2] && usr) return {1'b1, base + 4'd2, 3'b000, l[31:13]};
        if (kd == 2'd1 && cfg[19] && !l[1]) return {1'b1, base + 4'd3, 3'b000, l[31:13]};
        if (kd == 2'd2 && cfg[17] && !l[0]) return {1'b1, base + 4'd3, 3'b000, l[31:13]};
        if (cfg[16] && !l[3]) return {1'b1, base + 4'd1, 3'b000, l[31:13]};
        return {1'b0, base, (kd == 2'd2) && (cfg[17] || l[0]), l[1], 1'b1, l[31:13]};
      end
    end
    return {1'b1, base, 3'b000, 19'd0};
  endfunction

  task automatic write_ent(input int t, input int w, input int s,
                           input logic [31:0] h, input logic [31:0] l);
    @(negedge clk_i);
    wr_en_i = 1; wr_tlb_i = t[0]; wr_way_i = w[1:0]; wr_idx_i = s[3:0];
    wr_hi_i = h; wr_lo_i = l;
    m_hi[t][w][s] = h; m_lo[t][w][s] = l;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] kd, input logic usr,
                        input logic [7:0] pid, input logic [31:0] cfg, input string tag);
    logic [26:0] exp, act;
    @(negedge clk_i);
    lk_valid_i = 1; lk_vaddr_i = va; lk_kind_i = kd; lk_user_i = usr;
    lk_pid_i = pid; lk_cfg_i = cfg;
    exp = ref_lookup(va, kd, usr, pid, cfg);
    @(negedge clk_i);
    lk_valid_i = 0;
    act = {rs_fault_o, rs_vec_o, rs_perm_o, rs_ppn_o};
    check(rs_valid_o === 1'b1, "R7", "rs_valid", 32'(rs_valid_o), 32'd1);
    check(act === exp, tag, "lookup result", 32'(act), 32'(exp));
  endtask

  function automatic logic [31:0] pick_hi(input int s);
    logic [14:0] up;
    case ($urandom_range(2, 0))
      0: up = 15'h0000;
      1: up = 15'h0001;
      default: up = 15'h2abc;
    endcase
    return {up, s[3:0], 5'($urandom), 3'($urandom), 5'($urandom_range(2, 0))};
  endfunction

  task automatic run_flush(input logic [7:0] pid, input bit restart, input string tag);
    int exp_cnt = 0, got = 0, last_key = -1, done_at = 0;
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 16; s++)
          if (m_lo[t][w][s][3] && !m_lo[t][w][s][4] && m_hi[t][w][s][7:0] == pid) exp_cnt++;
    @(negedge clk_i);
    fl_start_i = 1; fl_pid_i = pid;
    @(negedge clk_i);
    fl_start_i = 0;
    check(fl_busy_o === 1'b1, tag, "busy after start", 32'(fl_busy_o), 32'd1);
    for (int k = 2; k < 200; k++) begin
      @(negedge clk_i);
      if (fl_hit_o) begin
        int key = {fl_tlb_o, fl_way_o, fl_idx_o};
        logic [31:0] h = m_hi[fl_tlb_o][fl_way_o][fl_idx_o];
        logic [31:0] l = m_lo[fl_tlb_o][fl_way_o][fl_idx_o];
        got++;
        check(l[3] && !l[4] && h[7:0] == pid, tag, "reported entry qualifies", 32'(key), 32'(pid));
        check(fl_vpn_o == h[31:13], tag, "reported vpn", 32'(fl_vpn_o), 32'(h[31:13]));
        check(key > last_key, tag, "scan order", 32'(key), 32'(last_key + 1));
        last_key = key;
      end
      if (fl_done_o) begin done_at = k; break; end
      if (restart && k == 10) begin fl_start_i = 1; fl_pid_i = pid + 8'd1; end
      if (restart && k == 11) fl_start_i = 0;
    end
    fl_start_i = 0;
    check(got == exp_cnt, tag, "flush match count", 32'(got), 32'(exp_cnt));
    check(done_at == 129, tag, "done cycle", 32'(done_at), 32'd129);
    @(negedge clk_i);
    check(fl_busy_o === 1'b0 && fl_done_o === 1'b0, tag, "idle after scan",
          32'({fl_busy_o, fl_done_o}), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 16; s++) begin m_hi[t][w][s] = '0; m_lo[t][w][s] = '0; end
    repeat (3) @(negedge clk_i);
    // R10: reset state
    check(rs_valid_o === 1'b0, "R10", "rs_valid at reset", 32'(rs_valid_o), 32'd0);
    check({fl_busy_o, fl_hit_o, fl_done_o} === 3'b000, "R10", "flush idle at reset",
          32'({fl_busy_o, fl_hit_o, fl_done_o}), 32'd0);
    rst_ni = 1;
    // R10: zeroed entries hit page 0 / tag 0 with no flags
    lookup(32'h0000_0123, 2'd0, 1'b0, 8'd0, 32'h0, "R10");
    lookup(32'h0000_0123, 2'd2, 1'b0, 8'd0, 32'h000f_0000, "R10");

    // R8: write then lookup next cycle
    write_ent(1, 2, 3, {19'h12343, 5'd0, 8'h55}, {19'h7_1234, 8'd0, 5'b01010});
    lookup({19'h12343, 13'h1ff}, 2'd1, 1'b0, 8'h55, 32'h000f_0000, "R8");
    lookup({19'h12343, 13'h1ff}, 2'd1, 1'b0, 8'h56, 32'h0, "R1");
    // R3: same address on exec goes to other buffer -> miss
    lookup({19'h12343, 13'h1ff}, 2'd2, 1'b0, 8'h55, 32'h0, "R3");
    lookup({19'h12343, 13'h1ff}, 2'd3, 1'b0, 8'h55, 32'h0, "R3");

    // R2: multi-way tie at set 5
    write_ent(1, 1, 5, {19'h00045, 5'd0, 8'h09}, {19'h0_aaaa, 8'd0, 5'b01010});
    write_ent(1, 2, 5, {19'h00045, 5'd0, 8'h33}, {19'h0_bbbb, 8'd0, 5'b11010});
    write_ent(1, 3, 5, {19'h00045, 5'd0, 8'h09}, {19'h0_cccc, 8'd0, 5'b01010});
    lookup({19'h00045, 13'h0}, 2'd0, 1'b0, 8'h09, 32'h0, "R2");
    lookup({19'h00045, 13'h0}, 2'd0, 1'b0, 8'h77, 32'h0, "R2");
    write_ent(1, 0, 5, {19'h00045, 5'd0, 8'h00}, {19'h0_dddd, 8'd0, 5'b11000});
    lookup({19'h00045, 13'h0}, 2'd0, 1'b0, 8'h09, 32'h0, "R2");

    // R4 R5 R6: every check-enable combination against a bare page
    for (int fl = 0; fl < 32; fl += 1) begin
      write_ent(0, 0, 7, {19'h00017, 5'd0, 8'h01}, {19'h5_5555, 8'd0, fl[4:0]});
      write_ent(1, 0, 7, {19'h00017, 5'd0, 8'h01}, {19'h5_5555, 8'd0, fl[4:0]});
      for (int c = 0; c < 16; c++)
        for (int kd = 0; kd < 3; kd++)
          for (int u = 0; u < 2; u++)
            lookup({19'h00017, 13'h10}, kd[1:0], u[0], 8'h01,
                   {12'hfff, c[3:0], 16'hffff} & 32'hfffb_ffff | {13'd0, c[2], 18'd0}, "R4");
    end

    // R1 R5 R6: random contents and lookups
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 16; s++)
          write_ent(t, w, s, pick_hi(s), {19'($urandom), 8'($urandom), 5'($urandom)});
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] va;
      case ($urandom_range(2, 0))
        0: va[31:17] = 15'h0000;
        1: va[31:17] = 15'h0001;
        default: va[31:17] = 15'h2abc;
      endcase
      va[16:0] = 17'($urandom);
      lookup(va, 2'($urandom), 1'($urandom), 8'($urandom_range(3, 0)), $urandom,
             (n % 2 == 0) ? "R1" : "R6");
    end

    // R7: no request -> no valid
    @(negedge clk_i);
    check(rs_valid_o === 1'b0, "R7", "rs_valid without request", 32'(rs_valid_o), 32'd0);

    // R9: flush scans, second one with an ignored restart
    run_flush(8'd1, 1'b0, "R9");
    run_flush(8'd2, 1'b1, "R9");
    run_flush(8'd0, 1'b0, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule